// File: doc/BRIEF.md
# Two-Digit Multiplexed Hex Display Scanner

This block drives a two-digit seven-segment display whose seven segment lines are wired to both digits in parallel. Each digit has its own enable line and lights only while that line is active. The block takes an 8-bit input and shows it as two hexadecimal characters. The low nibble goes to digit 0 and the high nibble goes to digit 1. A free-running slot timer alternates the two enables. The shared segment bus is reloaded with the pattern of whichever digit is about to be lit.

The refresh period is two slots of `CLKS_PER_HALF` clocks each. It must fall between 1 ms and 16 ms at the clock rate given by `CLK_HZ`, so that the display shows no flicker. A configuration outside that window stops elaboration. Separate parameters select active-high or active-low drive for the segment lines and for the enable lines. The same block therefore fits common-anode and common-cathode display wiring.

Top module: `hex2_scan`

## Requirements
- R1: Digit 0 (enable bit 0) shows `value[3:0]` and digit 1 (enable bit 1) shows `value[7:4]`.
- R2: Outside reset, at most one digit enable is active at any time. From the first clock edge after reset, exactly one enable is active.
- R3: In steady state each digit stays enabled for exactly `CLKS_PER_HALF` consecutive cycles, and the two digits alternate without end.
- R4: The enable lines and the segment bus change on the same clock edge. In every cycle the segment bus carries the pattern of the digit that is currently enabled.
- R5: Segment bit 0 is A and segment bit 6 is G, active-high before polarity. The patterns for nibbles 0 through F, written as {G..A}, are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. The characters b and d are shown in lower case.
- R6: While reset is sampled high, all segments and both enables are inactive. The first edge with reset low enables digit 0. That first slot lasts `CLKS_PER_HALF-1` cycles, and digit 1 follows it.
- R7: `SEG_ACT_LOW=1` inverts every segment line and `EN_ACT_LOW=1` inverts both enable lines. Timing is not affected.
- R8: A change on `value` reaches the segment bus one clock edge later while the same digit stays enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| value | input | 8 | Two hex nibbles to display |
| seg | output | 7 | Shared segment lines, bit 0 = A through bit 6 = G |
| dig_en | output | 2 | Digit enables, bit 0 = digit 0 |

## Verification
Every output is registered, so any cause shows at the pins one clock edge later. Causes include a change on `value`, a slot wrap and the release of reset. The bench changes inputs and reads outputs only at falling edges. After changing `value`, it lets one rising edge pass before it compares the segment pattern. The exception is the one-edge latency check, which reads on the very next falling edge. Slot lengths are measured as runs of consecutive falling-edge samples with the same enable. The first run after reset is expected one cycle short, because the enable first appears one edge after reset is released.

// File: rtl/hex2_scan.sv
module hex2_scan #(
  parameter int CLK_HZ        = 100_000_000,
  parameter int CLKS_PER_HALF = 400_000,
  parameter bit SEG_ACT_LOW   = 1'b1,
  parameter bit EN_ACT_LOW    = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] value,
  output logic [6:0] seg,
  output logic [1:0] dig_en
);

  localparam int CW = (CLKS_PER_HALF > 1) ? $clog2(CLKS_PER_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_HALF - 1);
  localparam longint PERIOD_CLKS = 2 * longint'(CLKS_PER_HALF);
  localparam longint MIN_CLKS    = longint'(CLK_HZ) / 1000;
  localparam longint MAX_CLKS    = (longint'(CLK_HZ) * 16) / 1000;

  if (PERIOD_CLKS < MIN_CLKS || PERIOD_CLKS > MAX_CLKS || CLKS_PER_HALF < 2) begin : g_bad_cfg
    initial $fatal(1, "hex2_scan: refresh period outside 1..16 ms");
  end

  function automatic logic [6:0] glyph(input logic [3:0] n);
    case (n)
      4'h0: glyph = 7'h3F;
      4'h1: glyph = 7'h06;
      4'h2: glyph = 7'h5B;
      4'h3: glyph = 7'h4F;
      4'h4: glyph = 7'h66;
      4'h5: glyph = 7'h6D;
      4'h6: glyph = 7'h7D;
      4'h7: glyph = 7'h07;
      4'h8: glyph = 7'h7F;
      4'h9: glyph = 7'h6F;
      4'hA: glyph = 7'h77;
      4'hB: glyph = 7'h7C;
      4'hC: glyph = 7'h39;
      4'hD: glyph = 7'h5E;
      4'hE: glyph = 7'h79;
      default: glyph = 7'h71;
    endcase
  endfunction

  logic [CW-1:0] cnt;
  logic          sel;
  logic          sel_nx;
  logic [6:0]    seg_act;
  logic [1:0]    en_act;

  assign sel_nx = (cnt == LAST) ? ~sel : sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      sel     <= 1'b0;
      seg_act <= '0;
      en_act  <= '0;
    end else begin
      cnt     <= (cnt == LAST) ? '0 : cnt + 1'b1;
      sel     <= sel_nx;
      en_act  <= sel_nx ? 2'b10 : 2'b01;
      seg_act <= glyph(sel_nx ? value[7:4] : value[3:0]);
    end
  end

  assign seg    = SEG_ACT_LOW ? ~seg_act : seg_act;
  assign dig_en = EN_ACT_LOW  ? ~en_act  : en_act;

  AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(en_act));                                                   // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);                                                        // R3
  AST_HOLD_SLOT: assert property (@(posedge clk) disable iff (rst)
    (en_act != 2'b00 && cnt != LAST) |=> $stable(en_act));               // R3
  AST_SWAP_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en_act != 2'b00 && cnt == LAST) |=> (en_act != $past(en_act)));     // R4
  AST_DARK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (en_act == 2'b00) |-> (seg_act == 7'h00));                           // R6
  AST_SEL_MATCH: assert property (@(posedge clk) disable iff (rst)
    (en_act != 2'b00) |-> (en_act[1] == sel));                           // R1

endmodule

// File: tb/hex2_scan_tb.sv
module hex2_scan_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HZ = 8000;
  localparam int N  = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] value = 8'h00;
  logic [6:0] seg, seg_lo;
  logic [1:0] dig_en, dig_en_lo;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hex2_scan #(.CLK_HZ(HZ), .CLKS_PER_HALF(N), .SEG_ACT_LOW(1'b0), .EN_ACT_LOW(1'b0)) dut_i (
    .clk(clk), .rst(rst), .value(value), .seg(seg), .dig_en(dig_en));

  hex2_scan #(.CLK_HZ(HZ), .CLKS_PER_HALF(N), .SEG_ACT_LOW(1'b1), .EN_ACT_LOW(1'b1)) dut_lo_i (
    .clk(clk), .rst(rst), .value(value), .seg(seg_lo), .dig_en(dig_en_lo));

  function automatic logic [6:0] exp_glyph(input logic [3:0] n);
    logic [6:0] t [16];
    t = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
          7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};
    return t[n];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run_len(output int len, output logic [1:0] next_en);
    logic [1:0] cur;
    cur = dig_en;
    len = 1;
    @(negedge clk);
    while (dig_en == cur && len < 4*N) begin
      len++;
      @(negedge clk);
    end
    next_en = dig_en;
  endtask

  task automatic t_reset;
    int len;
    logic [1:0] nx;
    rst = 1'b1;
    value = 8'h3C;
    repeat (3) @(negedge clk);
    chk(seg == 7'h00 && dig_en == 2'b00, "R6 dark in reset", {seg, dig_en}, 0);
    chk(seg_lo == 7'h7F && dig_en_lo == 2'b11, "R7 inverted dark in reset", {seg_lo, dig_en_lo}, 9'h1FF);
    rst = 1'b0;
    @(negedge clk);
    chk(dig_en == 2'b01, "R6 digit 0 first", dig_en, 1);
    chk(seg == exp_glyph(4'hC), "R1 low nibble on digit 0", seg, exp_glyph(4'hC));
    run_len(len, nx);
    chk(len == N-1, "R6 short first slot", len, N-1);
    chk(nx == 2'b10, "R6 digit 1 follows", nx, 2);
  endtask

  task automatic t_duty;
    int len;
    logic [1:0] cur, nx;
    for (int k = 0; k < 6; k++) begin
      cur = dig_en;
      run_len(len, nx);
      chk(len == N, "R3 slot length", len, N);
      chk(nx == ~cur, "R3 alternation", nx, ~cur);
      chk($countones(nx) == 1, "R2 one enable", nx, 0);
    end
  endtask

  task automatic t_patterns;
    logic [3:0] lo, hi;
    for (int n = 0; n < 16; n++) begin
      lo = 4'(n);
      hi = 4'(15 - n);
      value = {hi, lo};
      @(negedge clk);
      for (int c = 0; c < 2*N; c++) begin
        if (dig_en == 2'b01)
          chk(seg == exp_glyph(lo), "R5 digit 0 pattern", seg, exp_glyph(lo));
        else if (dig_en == 2'b10)
          chk(seg == exp_glyph(hi), "R4 digit 1 pattern", seg, exp_glyph(hi));
        else
          chk(1'b0, "R2 enable invalid", dig_en, 1);
        chk(seg_lo == ~seg && dig_en_lo == ~dig_en, "R7 polarity", {seg_lo, dig_en_lo}, {~seg, ~dig_en});
        @(negedge clk);
      end
    end
  endtask

  task automatic t_live;
    logic [1:0] prev;
    prev = dig_en;
    while (!(prev == 2'b10 && dig_en == 2'b01)) begin
      prev = dig_en;
      @(negedge clk);
    end
    value = 8'hA8;
    @(negedge clk);
    chk(dig_en == 2'b01, "R8 same digit", dig_en, 1);
    chk(seg == exp_glyph(4'h8), "R8 one edge latency", seg, exp_glyph(4'h8));
    value = 8'hA2;
    @(negedge clk);
    chk(seg == exp_glyph(4'h2), "R8 second update", seg, exp_glyph(4'h2));
    while (dig_en != 2'b10) @(negedge clk);
    chk(seg == exp_glyph(4'hA), "R1 high nibble on digit 1", seg, exp_glyph(4'hA));
  endtask

  initial begin
    t_reset();
    t_duty();
    t_patterns();
    t_live();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule